// File: doc/BRIEF.md
# Bridge Address Parity Responder

This block sits beside the two target interfaces of a two-port bus bridge, one facing upstream and one facing downstream. It watches each interface for the start of an address phase and latches the address, command/byte-enable lines and the external decoder's hit flag. It then waits one clock for the parity bit and checks even parity over the whole address phase. From that result it decides whether the decoded transaction may be claimed. The claim pulse it produces gates the interface's device-select driver. When the address is corrupt and parity checking is enabled for that interface, the claim is withheld, so the initiator ends the cycle in a master abort.

Every detected address parity error sets a sticky flag in that interface's status word. An error may also raise the system-error line, which is an active-low open-drain output, for one clock. This happens only when the upstream command register enables both parity response and system-error reporting, and a per-event disable bit does not mask it. The upstream status word records when that line has been signalled. Both status words are cleared by writing ones through a small register port.

Top module: `apr_responder`

## Requirements
- R1: Address parity is even over AD, C/BE and PAR. An error exists exactly when that set holds an odd number of ones, whatever the bus command on C/BE.
- R2: The address phase is the clock in which FRAME_L is low after being high in the previous clock. PAR is taken in the clock that follows. The claim and error-event outputs for that interface are high for exactly the one clock after the PAR clock.
- R3: On the primary interface, an address parity error with `cmd_per` = 1 produces no claim, even when the decoder hit.
- R4: With the governing parity-response bit at 0, a hit transaction is claimed even when its address parity is bad. A transaction that did not hit is never claimed.
- R5: On the secondary interface, only `brg_per` decides claim suppression, and `cmd_per` has no effect on it.
- R6: Every address parity error sets that interface's detected-parity flag (status bit 0), whatever the enable and mask bits are.
- R7: `serr_oe` and the signalled-error flag (primary status bit 1) are set only when the error coincides with `cmd_serr_en` = 1 and `cmd_per` = 1.
- R8: `serr_mask` bit 0 (primary event) or bit 1 (secondary event) suppresses `serr_oe` and the signalled-error flag for that interface's events, but not the detected-parity flag.
- R9: `serr_oe` is high for one clock per clock in which a qualifying event occurs. Simultaneous events on both interfaces give one clock.
- R10: Status words are read combinationally at `reg_addr` 0 (primary: bit0 detected parity, bit1 signalled error) and 1 (secondary: bit0 detected parity, bit1 reads 0). Writing a 1 clears a bit, writing a 0 leaves it unchanged, and a set in the same clock as a clear wins.
- R11: Reset clears both status words and holds `serr_oe` and all claim and event outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| p_frame_n | input | 1 | Primary FRAME_L |
| p_ad | input | AD_W | Primary address/data lines |
| p_cbe | input | CBE_W | Primary command/byte enables |
| p_par | input | 1 | Primary parity bit |
| p_hit | input | 1 | Primary decoder hit, valid in the address phase |
| s_frame_n | input | 1 | Secondary FRAME_L |
| s_ad | input | AD_W | Secondary address/data lines |
| s_cbe | input | CBE_W | Secondary command/byte enables |
| s_par | input | 1 | Secondary parity bit |
| s_hit | input | 1 | Secondary decoder hit |
| cmd_per | input | 1 | Command register parity-response enable |
| cmd_serr_en | input | 1 | Command register system-error enable |
| brg_per | input | 1 | Bridge control parity-response enable (secondary) |
| serr_mask | input | 2 | Per-event system-error disable |
| reg_wr | input | 1 | Status write strobe |
| reg_addr | input | 1 | Status word select |
| reg_wdata | input | REG_W | Write-one-to-clear data |
| reg_rdata | output | REG_W | Selected status word |
| p_claim | output | 1 | Primary claim permit pulse |
| s_claim | output | 1 | Secondary claim permit pulse |
| p_ape | output | 1 | Primary address parity error event |
| s_ape | output | 1 | Secondary address parity error event |
| serr_oe | output | 1 | Drive system-error line low |

## Verification
A latch captured on the wrong clock, or a parity tree that misses a lane, shows at the ports two clocks after the address phase. The claim or event pulse is then wrong in the clock after PAR. A swapped parity-response source shows only when `cmd_per` and `brg_per` differ, so the stimulus drives them independently. Sticky-flag faults show one clock later on the read port. A lost same-clock set shows only when a clear write is aimed at the update edge.

// File: rtl/apr_pkg.sv
package apr_pkg;
  localparam int APR_NSIDE    = 2;
  localparam int APR_SIDE_PRI = 0;
  localparam int APR_SIDE_SEC = 1;
  localparam int APR_PARV_W   = 128;
  localparam int APR_DPE_BIT  = 0;
  localparam int APR_SSE_BIT  = 1;

  // odd number of ones over the address phase means a parity fault
  function automatic logic apr_parity_fault(input logic [APR_PARV_W-1:0] v);
    return ^v;
  endfunction

  // claim permit: decoder hit, unless a fault is seen with response enabled
  function automatic logic apr_claim_ok(input logic hit, input logic fault,
                                        input logic per);
    return hit & ~(fault & per);
  endfunction

  // system error qualifies when both command enables are on and not masked
  function automatic logic apr_serr_ok(input logic fault, input logic serr_en,
                                       input logic per, input logic mask);
    return fault & serr_en & per & ~mask;
  endfunction

  // sticky flag update: a new set beats a simultaneous clear
  function automatic logic apr_w1c(input logic cur, input logic set,
                                   input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/apr_addr_check.sv
module apr_addr_check
  import apr_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic [AD_W-1:0]  ad,
  input  logic [CBE_W-1:0] cbe,
  input  logic             par,
  input  logic             hit,
  input  logic             claim_per,
  input  logic             serr_en,
  input  logic             serr_per,
  input  logic             serr_mask,
  output logic             addr_phase,
  output logic             par_fault,
  output logic             claim_go,
  output logic             ape_evt,
  output logic             serr_req
);
  localparam int VEC_W = AD_W + CBE_W + 1;
  localparam int PAD_W = APR_PARV_W - VEC_W;

  logic             frame_q;
  logic             pend_q;
  logic [AD_W-1:0]  ad_q;
  logic [CBE_W-1:0] cbe_q;
  logic             hit_q;
  logic [APR_PARV_W-1:0] par_vec;

  assign addr_phase = frame_q & ~frame_n;
  assign par_vec    = {{PAD_W{1'b0}}, ad_q, cbe_q, par};
  assign par_fault  = pend_q & apr_parity_fault(par_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b1;
      pend_q  <= 1'b0;
      ad_q    <= '0;
      cbe_q   <= '0;
      hit_q   <= 1'b0;
    end else begin
      frame_q <= frame_n;
      pend_q  <= addr_phase;
      if (addr_phase) begin
        ad_q  <= ad;
        cbe_q <= cbe;
        hit_q <= hit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_go <= 1'b0;
      ape_evt  <= 1'b0;
      serr_req <= 1'b0;
    end else begin
      claim_go <= pend_q & apr_claim_ok(hit_q, par_fault, claim_per);
      ape_evt  <= par_fault;
      serr_req <= apr_serr_ok(par_fault, serr_en, serr_per, serr_mask);
    end
  end
endmodule

// File: rtl/apr_serr_gen.sv
module apr_serr_gen #(
  parameter int NS = 2
) (
  input  logic [NS-1:0] req,
  output logic          serr_oe,
  output logic          sse_set
);
  // requests are already registered one-clock pulses
  assign serr_oe = |req;
  assign sse_set = |req;
endmodule

// File: rtl/apr_status_regs.sv
module apr_status_regs
  import apr_pkg::*;
#(
  parameter int NS    = 2,
  parameter int REG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NS-1:0]    dpe_set,
  input  logic             sse_set,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [NS-1:0]    dpe_q,
  output logic             sse_q
);
  logic [NS-1:0] sel;

  for (genvar g = 0; g < NS; g++) begin : g_side
    assign sel[g] = wr_en && (addr == 1'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dpe_q[g] <= 1'b0;
      else        dpe_q[g] <= apr_w1c(dpe_q[g], dpe_set[g],
                                      sel[g] & wdata[APR_DPE_BIT]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sse_q <= 1'b0;
    else        sse_q <= apr_w1c(sse_q, sse_set,
                                 sel[APR_SIDE_PRI] & wdata[APR_SSE_BIT]);
  end

  always_comb begin
    rdata = '0;
    rdata[APR_DPE_BIT] = dpe_q[addr];
    if (addr == 1'(APR_SIDE_PRI)) rdata[APR_SSE_BIT] = sse_q;
  end
endmodule

// File: rtl/apr_responder.sv
module apr_responder
  import apr_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4,
  parameter int REG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             p_frame_n,
  input  logic [AD_W-1:0]  p_ad,
  input  logic [CBE_W-1:0] p_cbe,
  input  logic             p_par,
  input  logic             p_hit,
  input  logic             s_frame_n,
  input  logic [AD_W-1:0]  s_ad,
  input  logic [CBE_W-1:0] s_cbe,
  input  logic             s_par,
  input  logic             s_hit,
  input  logic             cmd_per,
  input  logic             cmd_serr_en,
  input  logic             brg_per,
  input  logic [1:0]       serr_mask,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             p_claim,
  output logic             s_claim,
  output logic             p_ape,
  output logic             s_ape,
  output logic             serr_oe
);
  localparam int NS = APR_NSIDE;

  logic [NS-1:0]    frame_n_v, par_v, hit_v, per_v;
  logic [NS-1:0]    addr_phase_v, fault_v, claim_v, ape_v, req_v;
  logic [AD_W-1:0]  ad_v  [NS];
  logic [CBE_W-1:0] cbe_v [NS];
  logic [NS-1:0]    dpe_q;
  logic             sse_q;
  logic             sse_set;

  assign frame_n_v = {s_frame_n, p_frame_n};
  assign par_v     = {s_par, p_par};
  assign hit_v     = {s_hit, p_hit};
  assign per_v     = {brg_per, cmd_per};
  assign ad_v[APR_SIDE_PRI]  = p_ad;
  assign ad_v[APR_SIDE_SEC]  = s_ad;
  assign cbe_v[APR_SIDE_PRI] = p_cbe;
  assign cbe_v[APR_SIDE_SEC] = s_cbe;

  for (genvar g = 0; g < NS; g++) begin : g_chk
    apr_addr_check #(.AD_W(AD_W), .CBE_W(CBE_W)) u_side (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_n    (frame_n_v[g]),
      .ad         (ad_v[g]),
      .cbe        (cbe_v[g]),
      .par        (par_v[g]),
      .hit        (hit_v[g]),
      .claim_per  (per_v[g]),
      .serr_en    (cmd_serr_en),
      .serr_per   (cmd_per),
      .serr_mask  (serr_mask[g]),
      .addr_phase (addr_phase_v[g]),
      .par_fault  (fault_v[g]),
      .claim_go   (claim_v[g]),
      .ape_evt    (ape_v[g]),
      .serr_req   (req_v[g])
    );
  end

  apr_serr_gen #(.NS(NS)) u_serr (
    .req     (req_v),
    .serr_oe (serr_oe),
    .sse_set (sse_set)
  );

  apr_status_regs #(.NS(NS), .REG_W(REG_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .dpe_set (ape_v),
    .sse_set (sse_set),
    .wr_en   (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .dpe_q   (dpe_q),
    .sse_q   (sse_q)
  );

  assign p_claim = claim_v[APR_SIDE_PRI];
  assign s_claim = claim_v[APR_SIDE_SEC];
  assign p_ape   = ape_v[APR_SIDE_PRI];
  assign s_ape   = ape_v[APR_SIDE_SEC];
endmodule

// File: rtl/apr_checker.sv
module apr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       p_claim,
  input logic       s_claim,
  input logic       p_ape,
  input logic       s_ape,
  input logic       serr_oe,
  input logic       cmd_per,
  input logic       cmd_serr_en,
  input logic       brg_per,
  input logic [1:0] serr_mask,
  input logic [1:0] dpe_q,
  input logic       sse_q
);
  AST_CLAIM_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    p_claim |=> !p_claim); // R2
  AST_PRI_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (p_ape && $past(cmd_per)) |-> !p_claim); // R3
  AST_SEC_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ape && $past(brg_per)) |-> !s_claim); // R5
  AST_PRI_DPE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    p_ape |=> dpe_q[0]); // R6
  AST_SEC_DPE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    s_ape |=> dpe_q[1]); // R6
  AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe |-> $past(cmd_serr_en && cmd_per)); // R7
  AST_SERR_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe |=> sse_q); // R7
  AST_SERR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (p_ape && !s_ape && $past(serr_mask[0])) |-> !serr_oe); // R8
  AST_SERR_HAS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe |-> (p_ape || s_ape)); // R9
endmodule

bind apr_responder apr_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .p_claim     (p_claim),
  .s_claim     (s_claim),
  .p_ape       (p_ape),
  .s_ape       (s_ape),
  .serr_oe     (serr_oe),
  .cmd_per     (cmd_per),
  .cmd_serr_en (cmd_serr_en),
  .brg_per     (brg_per),
  .serr_mask   (serr_mask),
  .dpe_q       (dpe_q),
  .sse_q       (sse_q)
);

// File: tb/apr_responder_tb.sv
module apr_responder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        p_frame_n = 1'b1, s_frame_n = 1'b1;
  logic [31:0] p_ad = '0, s_ad = '0;
  logic [3:0]  p_cbe = '0, s_cbe = '0;
  logic        p_par = 1'b0, s_par = 1'b0, p_hit = 1'b0, s_hit = 1'b0;
  logic        cmd_per = 1'b0, cmd_serr_en = 1'b0, brg_per = 1'b0;
  logic [1:0]  serr_mask = '0;
  logic        reg_wr = 1'b0, reg_addr = 1'b0;
  logic [1:0]  reg_wdata = '0;
  logic [1:0]  reg_rdata;
  logic        p_claim, s_claim, p_ape, s_ape, serr_oe;

  int n_chk = 0, n_err = 0;
  logic [1:0] m_dpe = '0;
  logic       m_sse = 1'b0;
  bit         done = 1'b0;

  apr_responder u_dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ones(input logic [31:0] a, input logic [3:0] c, input logic p);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(a[i]);
    for (int i = 0; i < 4; i++)  n += int'(c[i]);
    return n + int'(p);
  endfunction

  function automatic logic fix_par(input logic [31:0] a, input logic [3:0] c);
    return (ones(a, c, 1'b0) % 2) == 1;
  endfunction

  task automatic read_status(input string tag);
    reg_addr = 1'b0; #1;
    chk({tag, " R10 pri status"}, 32'(reg_rdata), 32'({m_sse, m_dpe[0]}));
    reg_addr = 1'b1; #1;
    chk({tag, " R10 sec status"}, 32'(reg_rdata), 32'({1'b0, m_dpe[1]}));
  endtask

  // one address phase on selected sides; corrupt flips PAR; clr0 clears primary DPE at update edge
  task automatic run_txn(input logic [1:0] go, input logic [31:0] a0, input logic [31:0] a1,
                         input logic [3:0] c0, input logic [3:0] c1, input logic [1:0] corrupt,
                         input logic [1:0] hit, input logic clr0);
    logic [1:0] bad, claim_e;
    logic       serr_e;
    logic       pe0, pe1;
    @(negedge clk);
    p_frame_n = ~go[0]; s_frame_n = ~go[1];
    p_ad = a0; s_ad = a1; p_cbe = c0; s_cbe = c1; p_hit = hit[0]; s_hit = hit[1];
    @(negedge clk);
    p_par = fix_par(a0, c0) ^ corrupt[0];
    s_par = fix_par(a1, c1) ^ corrupt[1];
    p_ad = $urandom; s_ad = $urandom; p_hit = $urandom; s_hit = $urandom;
    pe0 = (ones(a0, c0, p_par) % 2) == 1;
    pe1 = (ones(a1, c1, s_par) % 2) == 1;
    bad[0] = go[0] & pe0;
    bad[1] = go[1] & pe1;
    claim_e[0] = go[0] & hit[0] & ~(bad[0] & cmd_per);
    claim_e[1] = go[1] & hit[1] & ~(bad[1] & brg_per);
    serr_e = cmd_serr_en & cmd_per & ((bad[0] & ~serr_mask[0]) | (bad[1] & ~serr_mask[1]));
    @(negedge clk);
    chk("R3 R4 p_claim", 32'(p_claim), 32'(claim_e[0]));
    chk("R4 R5 s_claim", 32'(s_claim), 32'(claim_e[1]));
    chk("R1 p_ape", 32'(p_ape), 32'(bad[0]));
    chk("R1 s_ape", 32'(s_ape), 32'(bad[1]));
    chk("R7 R8 serr_oe", 32'(serr_oe), 32'(serr_e));
    p_frame_n = 1'b1; s_frame_n = 1'b1;
    if (clr0) begin reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 2'b01; end
    m_dpe[0] = bad[0] | (m_dpe[0] & ~clr0);
    m_dpe[1] = bad[1] | m_dpe[1];
    m_sse    = serr_e | m_sse;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R2 p_claim drop", 32'(p_claim), 32'd0);
    chk("R2 s_claim drop", 32'(s_claim), 32'd0);
    chk("R9 serr_oe one clock", 32'(serr_oe), 32'd0);
    read_status("R6");
  endtask

  task automatic do_write(input logic addr, input logic [1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = addr; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (addr == 1'b0) begin m_dpe[0] &= ~d[0]; m_sse &= ~d[1]; end
    else m_dpe[1] &= ~d[0];
    read_status("R10 write");
  endtask

  task automatic set_ctl(input logic per, input logic sen, input logic bper, input logic [1:0] msk);
    cmd_per = per; cmd_serr_en = sen; brg_per = bper; serr_mask = msk;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 serr after reset", 32'(serr_oe), 32'd0);
    chk("R11 claim after reset", 32'({p_claim, s_claim, p_ape, s_ape}), 32'd0);
    read_status("R11");

    // R1: good parity claims; R3: bad primary with response on withheld, SERR raised (R7)
    set_ctl(1, 1, 0, 2'b00);
    run_txn(2'b01, 32'hDEAD_BEEF, 0, 4'h6, 0, 2'b00, 2'b01, 0);
    run_txn(2'b01, 32'h1234_5678, 0, 4'h7, 0, 2'b01, 2'b01, 0);
    // R4: response off, bad parity still claimed, no SERR (R7)
    set_ctl(0, 1, 0, 2'b00);
    run_txn(2'b01, 32'h0F0F_0000, 0, 4'hA, 0, 2'b01, 2'b01, 0);
    run_txn(2'b01, 32'h0F0F_0000, 0, 4'hA, 0, 2'b00, 2'b00, 0);
    // R5: secondary follows brg_per only
    set_ctl(0, 0, 1, 2'b00);
    run_txn(2'b10, 0, 32'hCAFE_0001, 0, 4'h3, 2'b10, 2'b10, 0);
    set_ctl(1, 0, 0, 2'b00);
    run_txn(2'b10, 0, 32'hCAFE_0001, 0, 4'h3, 2'b10, 2'b10, 0);
    // R8: masks
    set_ctl(1, 1, 1, 2'b01);
    run_txn(2'b01, 32'hFFFF_FFFF, 0, 4'hF, 0, 2'b01, 2'b01, 0);
    set_ctl(1, 1, 1, 2'b10);
    run_txn(2'b10, 0, 32'h8000_0001, 0, 4'h2, 2'b10, 2'b10, 0);
    // R9: both sides at once, one clock of SERR
    set_ctl(1, 1, 1, 2'b00);
    run_txn(2'b11, 32'h1, 32'h2, 4'h1, 4'h2, 2'b11, 2'b11, 0);
    // R10: zero write no effect, clear, then same-clock set wins
    do_write(1'b0, 2'b00);
    do_write(1'b1, 2'b00);
    do_write(1'b0, 2'b11);
    do_write(1'b1, 2'b01);
    run_txn(2'b01, 32'h55AA_55AA, 0, 4'h5, 0, 2'b01, 2'b01, 1);
    run_txn(2'b01, 32'h55AA_55AA, 0, 4'h5, 0, 2'b00, 2'b01, 1);

    for (int k = 0; k < 400; k++) begin
      logic [1:0] go;
      set_ctl($urandom, $urandom, $urandom, 2'($urandom));
      go = 2'($urandom);
      if (go == 2'b00) go = 2'b01;
      run_txn(go, $urandom, $urandom, 4'($urandom), 4'($urandom),
              2'($urandom), 2'($urandom), ($urandom % 5) == 0);
      if (($urandom % 8) == 0) do_write($urandom, 2'($urandom));
    end

    // R11: reset mid-run clears sticky state
    set_ctl(1, 1, 1, 2'b00);
    run_txn(2'b11, 32'h3, 32'h7, 4'h0, 4'h0, 2'b11, 2'b11, 0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_dpe = '0; m_sse = 1'b0;
    read_status("R11 re-reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule